// File: doc/BRIEF.md
# Sign-First Successive Approximation Conversion Controller

This block sequences one 12-bit-plus-sign successive approximation conversion. It works against an external comparator and DAC. The controller drives a magnitude code and a sign level towards the DAC. It samples a single comparator bit once per clock and builds the result one decision at a time. Polarity is settled first: the held input is compared with ground, with the DAC code at zero. The twelve magnitude bits are then tried from the most significant bit down to the least significant bit. When the last bit is settled, the 13-bit result goes into an output latch. At the same edge, end-of-conversion rises and the active-low interrupt falls.

A conversion is started by the rising edge of a write strobe or of a sample/hold strobe, either one qualified by an active-low chip-select. When auto-zero is selected and the conversion was started by the write strobe, a fixed-length zeroing phase runs before the sign decision. During that phase a restart is still legal. At every other moment a conversion in flight can only be restarted after end-of-conversion is high again. After reset, a calibration phase of fixed length runs and cannot be interrupted. The calibration itself is modelled only as busy time. Starts that arrive when they are not legal are dropped, and a sticky flag records them.

Top module: `sign_sar_ctrl`

## Requirements
- R1: After reset, `eocOut` stays low for exactly CAL_CYCLES clocks of calibration, and then rises. Every start seen during that time is dropped and sets `rejectFlag`.
- R2: The first decision of a conversion is taken with `dacCode` equal to 0. The sign bit is 0 when the comparator reads 1 (input at or above ground) and 1 otherwise. The sign is placed in `resultOut[12]` and shown on `dacSign`.
- R3: Magnitude trials run one per clock, from bit 11 down to bit 0. Each trial sets its bit on `dacCode` and keeps it only if the comparator reads 1 (input above the DAC code). The final `resultOut[11:0]` is therefore the largest code strictly below the input magnitude, or 0 when the magnitude is 0.
- R4: Without the zeroing phase, `eocOut` is low for exactly 13 clocks from the edge that accepts a start. With the zeroing phase, it is low for exactly AZ_CYCLES + 13 clocks.
- R5: At the edge that settles the last bit, three things happen together: `resultOut` takes the new {sign, magnitude}, `eocOut` rises, and `intN` falls.
- R6: A start is a rising edge of `wrN` or of `shN` seen at a clock edge while `csN` is low. With `csN` high, strobes do nothing. When both strobes rise together, the start counts as a sample/hold start.
- R7: In a conversion without the zeroing phase, a start arriving while `eocOut` is low is dropped and sets `rejectFlag`. The conversion still completes on its original schedule.
- R8: When `autoZeroEn` is 1 and a write strobe starts the conversion, a new start is accepted during the first AZ_CYCLES clocks after that edge, and the conversion begins again. From the next clock on, starts are dropped and flagged.
- R9: `intN` returns high at the edge of an accepted start, or at the edge of a read (`csN` and `rdN` both low). If a read and a completion fall on the same edge, the completion wins.
- R10: `rejectFlag` stays set until a read clears it. A drop on the same edge as a read leaves it set.
- R11: `resultOut` holds its value while a later conversion runs, and changes only when that conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts calibration |
| csN | input | 1 | Active-low chip-select qualifying all strobes |
| wrN | input | 1 | Write strobe; its rising edge starts a conversion |
| shN | input | 1 | Sample/hold strobe; low tracks, its rising edge holds and starts |
| rdN | input | 1 | Active-low read strobe; clears the interrupt and the drop flag |
| autoZeroEn | input | 1 | Selects the zeroing phase for write-started conversions |
| cmpIn | input | 1 | Comparator: 1 when the held input exceeds the DAC level |
| dacCode | output | 12 | Magnitude code driven to the DAC |
| dacSign | output | 1 | Resolved sign driven to the DAC |
| resultOut | output | 13 | Latched result: bit 12 is the sign, bits 11:0 the magnitude |
| eocOut | output | 1 | High when no conversion or calibration is running |
| intN | output | 1 | Active-low completion interrupt |
| rejectFlag | output | 1 | Sticky record of a dropped start |

## Verification
The bench tests magnitudes at the edges of the range: zero, one, exact full scale, and a negative full scale. A design that used a non-strict comparison, or lost the last trial, would return a result one code too high or too low. It places restarts just inside and just outside the zeroing window, and mid-conversion without zeroing. A design with the window off by one, or one that applied the window to sample/hold starts, would change the length of `eocOut`-low or raise `rejectFlag` at the wrong time. It also checks strobes while chip-select is high, two strobes on the same edge, starts during calibration, and a result latch that must not move while a later conversion runs.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    ST_CAL,
    ST_IDLE,
    ST_ZERO,
    ST_SIGN,
    ST_TRIAL
  } ctrlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;      // new conversion accepted: empty the trial register
    logic signStep;   // sign decision on this edge, MSB trial loaded
    logic trialStep;  // one magnitude decision on this edge
    logic latch;      // final decision: copy into the result latch
  } dpStrobe_t;

endpackage

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int MAG_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                cmpIn,
  output logic [MAG_BITS-1:0] dacCode,
  output logic                dacSign,
  output logic                lastTrial,
  output logic [MAG_BITS:0]   resultOut
);

  localparam logic [MAG_BITS-1:0] TOP_BIT = {1'b1, {(MAG_BITS-1){1'b0}}};

  logic [MAG_BITS-1:0] sarReg;
  logic [MAG_BITS-1:0] trialMask;
  logic [MAG_BITS-1:0] sarNext;
  logic [MAG_BITS-1:0] maskNext;
  logic                signBit;
  logic [MAG_BITS:0]   resultReg;

  always_comb begin
    sarNext  = sarReg;
    maskNext = trialMask;
    if (strobe.clear) begin
      sarNext  = '0;
      maskNext = '0;
    end else if (strobe.signStep) begin
      sarNext  = TOP_BIT;
      maskNext = TOP_BIT;
    end else if (strobe.trialStep) begin
      maskNext = trialMask >> 1;
      sarNext  = (cmpIn ? sarReg : (sarReg & ~trialMask)) | maskNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
    end else begin
      sarReg    <= sarNext;
      trialMask <= maskNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signBit <= 1'b0;
    end else if (strobe.clear) begin
      signBit <= 1'b0;
    end else if (strobe.signStep) begin
      signBit <= ~cmpIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (strobe.latch) begin
      resultReg <= {signBit, sarNext};
    end
  end

  assign dacCode   = sarReg;
  assign dacSign   = signBit;
  assign lastTrial = trialMask[0];
  assign resultOut = resultReg;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int CAL_CYCLES = 1399,
  parameter int AZ_CYCLES  = 26
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      wrN,
  input  logic      shN,
  input  logic      rdN,
  input  logic      autoZeroEn,
  input  logic      lastTrial,
  output dpStrobe_t strobe,
  output logic      eocOut,
  output logic      intN,
  output logic      rejectFlag
);

  localparam int CNT_MAX = (CAL_CYCLES > AZ_CYCLES) ? CAL_CYCLES : AZ_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CAL_LOAD = CNT_W'(CAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] AZ_LOAD  = CNT_W'(AZ_CYCLES - 1);

  ctrlState_t      state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseCntNext;
  logic             wrPrev, shPrev;
  logic             wrRise, shRise, startReq, useZero, readReq;
  logic             canStart, accept, drop, finish;

  // Strobe edge detection, qualified by chip-select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      shPrev <= 1'b1;
    end else begin
      wrPrev <= wrN;
      shPrev <= shN;
    end
  end

  assign wrRise   = !csN && !wrPrev && wrN;
  assign shRise   = !csN && !shPrev && shN;
  assign startReq = wrRise || shRise;
  assign useZero  = autoZeroEn && wrRise && !shRise;
  assign readReq  = !csN && !rdN;

  assign canStart = (state == ST_IDLE) || (state == ST_ZERO);
  assign accept   = startReq && canStart;
  assign drop     = startReq && !canStart;
  assign finish   = (state == ST_TRIAL) && lastTrial;

  always_comb begin
    stateNext    = state;
    phaseCntNext = phaseCnt;
    if (accept) begin
      stateNext    = useZero ? ST_ZERO : ST_SIGN;
      phaseCntNext = useZero ? AZ_LOAD : '0;
    end else begin
      unique case (state)
        ST_CAL: begin
          if (phaseCnt == '0) stateNext = ST_IDLE;
          else                phaseCntNext = phaseCnt - 1'b1;
        end
        ST_ZERO: begin
          if (phaseCnt == '0) stateNext = ST_SIGN;
          else                phaseCntNext = phaseCnt - 1'b1;
        end
        ST_SIGN:  stateNext = ST_TRIAL;
        ST_TRIAL: if (lastTrial) stateNext = ST_IDLE;
        default:  stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CAL;
      phaseCnt <= CAL_LOAD;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseCntNext;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clear     = accept;
    strobe.signStep  = (state == ST_SIGN);
    strobe.trialStep = (state == ST_TRIAL);
    strobe.latch     = finish;
  end

  // Flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocOut <= 1'b0;
    end else if (accept) begin
      eocOut <= 1'b0;
    end else if (finish || ((state == ST_CAL) && (phaseCnt == '0))) begin
      eocOut <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intN <= 1'b1;
    end else if (finish) begin
      intN <= 1'b0;
    end else if (accept || readReq) begin
      intN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rejectFlag <= 1'b0;
    end else if (drop) begin
      rejectFlag <= 1'b1;
    end else if (readReq) begin
      rejectFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/sign_sar_ctrl.sv
module sign_sar_ctrl
  import sar_pkg::*;
#(
  parameter int MAG_BITS   = 12,
  parameter int CAL_CYCLES = 1399,
  parameter int AZ_CYCLES  = 26
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                wrN,
  input  logic                shN,
  input  logic                rdN,
  input  logic                autoZeroEn,
  input  logic                cmpIn,
  output logic [MAG_BITS-1:0] dacCode,
  output logic                dacSign,
  output logic [MAG_BITS:0]   resultOut,
  output logic                eocOut,
  output logic                intN,
  output logic                rejectFlag
);

  dpStrobe_t strobe;
  logic      lastTrial;

  sar_ctrl #(
    .CAL_CYCLES(CAL_CYCLES),
    .AZ_CYCLES (AZ_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .wrN       (wrN),
    .shN       (shN),
    .rdN       (rdN),
    .autoZeroEn(autoZeroEn),
    .lastTrial (lastTrial),
    .strobe    (strobe),
    .eocOut    (eocOut),
    .intN      (intN),
    .rejectFlag(rejectFlag)
  );

  sar_datapath #(
    .MAG_BITS(MAG_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmpIn    (cmpIn),
    .dacCode  (dacCode),
    .dacSign  (dacSign),
    .lastTrial(lastTrial),
    .resultOut(resultOut)
  );

endmodule

// File: rtl/sign_sar_ctrl_chk.sv
module sign_sar_ctrl_chk #(
  parameter int MAG_BITS   = 12,
  parameter int CAL_CYCLES = 1399
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                rdN,
  input logic [MAG_BITS-1:0] dacCode,
  input logic [MAG_BITS:0]   resultOut,
  input logic                eocOut,
  input logic                intN,
  input logic                rejectFlag
);

  localparam int SR_W = $clog2(CAL_CYCLES + 2);

  logic [SR_W-1:0] sinceRst;
  logic            readNow;

  assign readNow = !csN && !rdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst <= SR_W'(CAL_CYCLES)) sinceRst <= sinceRst + 1'b1;
  end

  // R1
  cal_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SR_W'(CAL_CYCLES)) |-> !eocOut);

  // R3
  one_trial_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eocOut && !$past(eocOut) && (dacCode != '0) && ($past(dacCode) != '0))
      |-> ($countones(dacCode ^ $past(dacCode)) <= 2));

  // R5
  result_with_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultOut) |-> (eocOut && !intN));

  // R9
  read_clears_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readNow && eocOut) |=> intN);

  // R10
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rejectFlag && !readNow) |=> rejectFlag);

endmodule

bind sign_sar_ctrl sign_sar_ctrl_chk #(
  .MAG_BITS  (MAG_BITS),
  .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .rdN       (rdN),
  .dacCode   (dacCode),
  .resultOut (resultOut),
  .eocOut    (eocOut),
  .intN      (intN),
  .rejectFlag(rejectFlag)
);

// File: tb/tb_sign_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sign_sar_ctrl;

  localparam int MAG_BITS   = 12;
  localparam int CAL_CYCLES = 1399;
  localparam int AZ_CYCLES  = 26;
  localparam int CONV_LEN   = MAG_BITS + 1;
  localparam int FULL       = (1 << MAG_BITS) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, shN = 1'b1, rdN = 1'b1, autoZeroEn = 1'b0;
  logic cmpIn;
  logic [MAG_BITS-1:0] dacCode;
  logic dacSign;
  logic [MAG_BITS:0] resultOut;
  logic eocOut, intN, rejectFlag;

  int vin = 0;
  int absV;
  int checks = 0, fails = 0, cyc = 0, edgesSinceRst = 0;

  always #4 clk = ~clk;

  assign absV  = (vin < 0) ? -vin : vin;
  assign cmpIn = (dacCode == '0) ? (vin >= 0) : (absV > int'(dacCode));

  sign_sar_ctrl #(.MAG_BITS(MAG_BITS), .CAL_CYCLES(CAL_CYCLES), .AZ_CYCLES(AZ_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .shN(shN), .rdN(rdN),
    .autoZeroEn(autoZeroEn), .cmpIn(cmpIn), .dacCode(dacCode), .dacSign(dacSign),
    .resultOut(resultOut), .eocOut(eocOut), .intN(intN), .rejectFlag(rejectFlag)
  );

  function automatic int expResult(int v);
    int m, mag;
    m = (v < 0) ? -v : v;
    if (m == 0) mag = 0;
    else if (m - 1 > FULL) mag = FULL;
    else mag = m - 1;
    return ((v < 0) ? (1 << MAG_BITS) : 0) + mag;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: remaining-time counters, no state machine
  int mCal, mBusy, mZero, mPending, mRes;
  bit mEoc, mInt, mRej, mPrevWr, mPrevSh;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCal = CAL_CYCLES; mBusy = 0; mZero = 0; mPending = 0; mRes = 0;
      mEoc = 0; mInt = 1; mRej = 0; mPrevWr = 1; mPrevSh = 1;
    end else begin
      bit wrR, shR, st, zr, rd, doneNow, dropNow;
      wrR = !csN && !mPrevWr && wrN;
      shR = !csN && !mPrevSh && shN;
      mPrevWr = wrN; mPrevSh = shN;
      st = wrR || shR;
      zr = autoZeroEn && wrR && !shR;
      rd = !csN && !rdN;
      doneNow = 0; dropNow = 0;
      if (mCal > 0) begin
        if (st) dropNow = 1;
        mCal--;
        if (mCal == 0) mEoc = 1;
      end else if (st && (mBusy == 0 || mZero > 0)) begin
        mEoc = 0; mInt = 1;
        mZero = zr ? AZ_CYCLES : 0;
        mBusy = CONV_LEN + mZero;
        mPending = expResult(vin);
      end else begin
        if (st) dropNow = 1;
        if (mBusy > 0) begin
          mBusy--;
          if (mZero > 0) mZero--;
          if (mBusy == 0) begin
            mEoc = 1; mInt = 0; mRes = mPending; doneNow = 1;
          end
        end
      end
      if (dropNow) mRej = 1;
      else if (rd) mRej = 0;
      if (rd && !doneNow) mInt = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rstN) edgesSinceRst++;
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      check(eocOut == mEoc, "R4 eocOut vs model", eocOut, mEoc);
      check(intN == mInt, "R9 intN vs model", intN, mInt);
      check(rejectFlag == mRej, "R10 rejectFlag vs model", rejectFlag, mRej);
      check(int'(resultOut) == mRes, "R11 resultOut vs model", resultOut, mRes);
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic startPulse(input bit useWr, input bit useSh, input bit cs);
    @(negedge clk);
    csN = !cs;
    if (useWr) wrN = 1'b0;
    if (useSh) shN = 1'b0;
    @(negedge clk);
    wrN = 1'b1; shN = 1'b1;
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic readPulse();
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic waitEoc(output int lowCnt);
    lowCnt = 0;
    while (!eocOut && lowCnt < 200) begin
      lowCnt++;
      @(negedge clk);
    end
  endtask

  task automatic convert(input int v, input bit useWr, input bit az, input int expLen, input string tag);
    int n;
    vin = v; autoZeroEn = az;
    startPulse(useWr, !useWr, 1'b1);
    waitEoc(n);
    check(n == expLen, {tag, " R4 conversion length"}, n, expLen);
    check(int'(resultOut) == expResult(v), {tag, " R2 R3 result"}, resultOut, expResult(v));
    check(intN == 1'b0, {tag, " R5 interrupt low on completion"}, intN, 0);
    readPulse();
    @(negedge clk);
    check(intN == 1'b1, {tag, " R9 read releases interrupt"}, intN, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(eocOut == 1'b0 && intN == 1'b1 && rejectFlag == 1'b0 && resultOut == '0,
          "R1 reset state", {eocOut, intN, rejectFlag}, 3'b010);
    rstN = 1'b1;

    // Start during calibration is dropped
    repeat (5) @(negedge clk);
    startPulse(1'b0, 1'b1, 1'b1);
    check(rejectFlag == 1'b1, "R1 start dropped during calibration", rejectFlag, 1);
    check(eocOut == 1'b0, "R1 calibration not interrupted", eocOut, 0);
    readPulse();
    @(negedge clk);
    check(rejectFlag == 1'b0, "R10 read clears drop flag", rejectFlag, 0);

    while (!eocOut && cyc < 5000) @(negedge clk);
    check(edgesSinceRst == CAL_CYCLES, "R1 calibration length", edgesSinceRst, CAL_CYCLES);

    // Several input patterns, sample/hold starts
    convert(1000, 1'b0, 1'b0, CONV_LEN, "pos mid");
    convert(-1, 1'b0, 1'b0, CONV_LEN, "neg one");
    convert(0, 1'b0, 1'b0, CONV_LEN, "zero");
    convert(1, 1'b0, 1'b0, CONV_LEN, "pos one");
    convert(4096, 1'b0, 1'b0, CONV_LEN, "pos full");
    convert(-4096, 1'b0, 1'b0, CONV_LEN, "neg full");
    convert(-2731, 1'b1, 1'b0, CONV_LEN, "write no zeroing");
    convert(1365, 1'b1, 1'b1, CONV_LEN + AZ_CYCLES, "write with zeroing");
    convert(777, 1'b0, 1'b1, CONV_LEN, "R8 sh start ignores zeroing");

    // R6: strobes with chip-select high do nothing
    startPulse(1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check(eocOut == 1'b1 && rejectFlag == 1'b0, "R6 deselected strobe ignored",
          {eocOut, rejectFlag}, 2'b10);

    // R6: both strobes together count as sample/hold (no zeroing)
    vin = -300; autoZeroEn = 1'b1;
    startPulse(1'b1, 1'b1, 1'b1);
    waitEoc(n);
    check(n == CONV_LEN, "R6 simultaneous strobes take sample/hold path", n, CONV_LEN);
    readPulse();

    // R7 and R11: restart mid-conversion without zeroing is dropped
    vin = 2000; autoZeroEn = 1'b0;
    startPulse(1'b0, 1'b1, 1'b1);
    check(int'(resultOut) == expResult(-300), "R11 result held during conversion",
          resultOut, expResult(-300));
    startPulse(1'b0, 1'b1, 1'b1);
    check(rejectFlag == 1'b1, "R7 mid-conversion restart dropped", rejectFlag, 1);
    waitEoc(n);
    check(n == CONV_LEN - 3, "R7 original schedule kept", n, CONV_LEN - 3);
    check(int'(resultOut) == expResult(2000), "R7 result", resultOut, expResult(2000));
    readPulse();

    // R8: restart inside the zeroing window is accepted
    vin = 55; autoZeroEn = 1'b1;
    startPulse(1'b1, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    startPulse(1'b1, 1'b0, 1'b1);
    check(rejectFlag == 1'b0, "R8 restart inside window accepted", rejectFlag, 0);
    waitEoc(n);
    check(n == CONV_LEN + AZ_CYCLES, "R8 restart runs full length", n, CONV_LEN + AZ_CYCLES);
    readPulse();

    // R8: restart just after the window is dropped
    startPulse(1'b1, 1'b0, 1'b1);
    repeat (AZ_CYCLES - 2) @(negedge clk);
    startPulse(1'b1, 1'b0, 1'b1);
    check(rejectFlag == 1'b1, "R8 restart after window dropped", rejectFlag, 1);
    waitEoc(n);
    check(eocOut == 1'b1, "R8 conversion completes", eocOut, 1);
    readPulse();
    @(negedge clk);
    check(rejectFlag == 1'b0 && intN == 1'b1, "R10 R9 read clears both",
          {rejectFlag, intN}, 2'b01);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule